// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the sending half of an asynchronous serial port. A host places one character at a time into a holding register. Whenever the shift stage has nothing to send, or is finishing the stop bit of the current character, the block moves the pending character into a shift register on its own. The shift register then puts a frame on the serial line: a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. The line rests high between frames.

Three flags report progress. `hold_ready` shows that the holding register is free. `shift_empty` shows that no frame is on the line. `overrun` records that the host wrote while the holding register was still occupied; it stays set until `ovr_clr` is pulsed. The divider sets the time of each bit. It uses a 16-bit `divisor` input, read again at each bit boundary, or a fixed build-time value. A break input forces the line low at once without stopping the frame sequencer.

The sequencer has five states: IDLE (line high, nothing to send), START, DATA, PARITY and STOP. Its transitions are these. IDLE→START when the holding register is full (the load). START→DATA on a bit tick. DATA→DATA on ticks until the last data bit. DATA→PARITY on the last data bit's tick when parity is enabled, otherwise DATA→STOP. PARITY→STOP on a tick. At the stop bit's tick, STOP→START when a character is pending (back-to-back load), otherwise STOP→IDLE.

Top module: `serial_tx`

## Requirements
- R1: Data bits leave least significant first. The data width is a build parameter of 7 or 8 bits (default 8).
- R2: A pending character is loaded without host action. The load happens one cycle after the write on an idle line, or at the end of the current stop bit, so that frames follow one another with no idle bit between them. `hold_ready` stays 0 while a character waits behind a frame in progress.
- R3: The clock edge that captures a write clears `hold_ready`. On an idle transmitter, `hold_ready` returns to 1 on the next edge, and on that same edge `txd` goes to 0 for the start bit.
- R4: A write while `hold_ready` is 0 sets `overrun` and replaces the pending character with the new one. `overrun` stays 1 until an `ovr_clr` pulse clears it. A write that overruns in the same cycle as `ovr_clr` leaves it set.
- R5: `shift_empty` is 0 from the load of a character until its stop bit ends with nothing pending, and 1 otherwise.
- R6: While `brk_force` is 1, `txd` is 0 in the same cycle, whatever the frame state. Frame timing carries on underneath, and the frame still finishes.
- R7: Each bit lasts `divisor`+1 clock cycles. With the fixed-rate build option, the build-time divisor is used instead.
- R8: A frame is a start bit of 0, then the data bits, then a parity bit, then a stop bit of 1. The parity is even by default: the parity bit makes the count of ones in data plus parity even. Odd parity or no parity bit can be chosen at build time. The idle line is 1.
- R9: A change of `divisor` during a bit does not change that bit's length. It takes effect from the next bit boundary.
- R10: After reset, `txd`=1, `hold_ready`=1, `shift_empty`=1 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_BITS | Character to send |
| ovr_clr | input | 1 | Clears the overrun flag |
| divisor | input | 16 | Run-time bit divisor (bit time = divisor+1 clocks) |
| brk_force | input | 1 | Forces the serial line low while 1 |
| txd | output | 1 | Serial output line |
| hold_ready | output | 1 | Holding register free |
| shift_empty | output | 1 | No frame in progress |
| overrun | output | 1 | Host wrote while holding register full |

## Verification
The hardest case to reach from the ports is a `divisor` change that lands inside a bit. Its effect shows only in the length of the line's low run. The bench sends a character whose first two line bits are low (start bit, then a 0 in data bit 0). It raises `divisor` in the first cycle of the start bit and checks that the low run equals the old bit time plus the new one. The overrun case needs a third write while one character is shifting and another is pending. The scoreboard then has to expect the newest character in place of the one that was overwritten.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } parity_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } frame_state_e;

    localparam int unsigned DIV_W = 16;

endpackage

// File: rtl/stx_baud.sv
module stx_baud
    import stx_pkg::*;
#(
    parameter bit               FIXED_RATE = 1'b0,
    parameter logic [DIV_W-1:0] FIXED_DIV  = 16'd433
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);

    logic [DIV_W-1:0] div_sel;
    logic [DIV_W-1:0] cnt_q;

    generate
        if (FIXED_RATE) begin : g_fixed
            assign div_sel = FIXED_DIV;
        end else begin : g_runtime
            assign div_sel = divisor;
        end
    endgenerate

    assign tick = (cnt_q == '0);

    // The divisor is sampled only when a bit starts, so a change mid-bit waits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= div_sel;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/stx_hold.sv
module stx_hold #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 load,
    input  logic                 ovr_clr,
    output logic                 full,
    output logic [DATA_BITS-1:0] data,
    output logic                 overrun
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en) begin
                data <= wr_data;
                full <= 1'b1;
            end else if (load) begin
                full <= 1'b0;
            end
        end
    end

    // Setting wins over clearing so an overrun event is never lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else begin
            overrun <= (wr_en && full) || (overrun && !ovr_clr);
        end
    end

endmodule

// File: rtl/stx_shift.sv
module stx_shift
    import stx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter parity_e     PARITY    = PAR_EVEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 hold_full,
    input  logic [DATA_BITS-1:0] hold_data,
    output logic                 load,
    output logic                 line,
    output logic                 busy
);

    localparam int unsigned CNT_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS - 1);
    localparam bit  HAS_PAR = (PARITY != PAR_NONE);
    localparam bit  ODD_PAR = (PARITY == PAR_ODD);

    frame_state_e         state_q, state_d;
    logic [DATA_BITS-1:0] sh_q;
    logic [CNT_W-1:0]     bit_q;
    logic                 par_q;
    logic                 last_bit;

    assign last_bit = (bit_q == LAST_BIT);

    // Hand-off: from idle, or straight out of the stop bit for back-to-back frames
    assign load = hold_full && ((state_q == ST_IDLE) || ((state_q == ST_STOP) && tick));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full) state_d = ST_START;
            end
            ST_START: begin
                if (tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (tick && last_bit) state_d = HAS_PAR ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (tick) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (tick) state_d = hold_full ? ST_START : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= hold_data;
            bit_q <= '0;
            par_q <= (^hold_data) ^ ODD_PAR;
        end else if ((state_q == ST_DATA) && tick) begin
            sh_q  <= sh_q >> 1;
            bit_q <= bit_q + 1'b1;
        end
    end

    always_comb begin
        line = 1'b1;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                line = 1'b1;
                busy = 1'b0;
            end
            ST_START:  line = 1'b0;
            ST_DATA:   line = sh_q[0];
            ST_PARITY: line = par_q;
            ST_STOP:   line = 1'b1;
            default: begin
                line = 1'b1;
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import stx_pkg::*;
#(
    parameter int unsigned      DATA_BITS  = 8,
    parameter parity_e          PARITY     = PAR_EVEN,
    parameter bit               FIXED_RATE = 1'b0,
    parameter logic [DIV_W-1:0] FIXED_DIV  = 16'd433
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 ovr_clr,
    input  logic [15:0]          divisor,
    input  logic                 brk_force,
    output logic                 txd,
    output logic                 hold_ready,
    output logic                 shift_empty,
    output logic                 overrun
);

    logic                 tick;
    logic                 load;
    logic                 hold_full;
    logic [DATA_BITS-1:0] hold_data;
    logic                 line;
    logic                 busy;

    stx_baud #(
        .FIXED_RATE (FIXED_RATE),
        .FIXED_DIV  (FIXED_DIV)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .divisor (divisor),
        .tick    (tick)
    );

    stx_hold #(
        .DATA_BITS (DATA_BITS)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load    (load),
        .ovr_clr (ovr_clr),
        .full    (hold_full),
        .data    (hold_data),
        .overrun (overrun)
    );

    stx_shift #(
        .DATA_BITS (DATA_BITS),
        .PARITY    (PARITY)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .load      (load),
        .line      (line),
        .busy      (busy)
    );

    assign txd         = brk_force ? 1'b0 : line;
    assign hold_ready  = !hold_full;
    assign shift_empty = !busy;

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic ovr_clr,
    input logic brk_force,
    input logic txd,
    input logic hold_ready,
    input logic shift_empty,
    input logic overrun
);

    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> !txd); // R6

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !brk_force) |-> txd); // R8

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> (!txd)); // R3

    AST_IDLE_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !hold_ready && !wr_en) |=> (hold_ready && !shift_empty)); // R2

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold_ready) |=> overrun); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun); // R4

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !shift_empty) |=> !hold_ready); // R2

endmodule

bind serial_tx stx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .ovr_clr     (ovr_clr),
    .brk_force   (brk_force),
    .txd         (txd),
    .hold_ready  (hold_ready),
    .shift_empty (shift_empty),
    .overrun     (overrun)
);

// File: tb/serial_tx_test.sv
module serial_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        ovr_clr = 1'b0;
    logic [15:0] divisor = 16'd3;
    logic        brk_force = 1'b0;
    logic        txd, hold_ready, shift_empty, overrun;

    int checks = 0;
    int errors = 0;
    int period = 4;
    bit mon_on = 1'b0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    serial_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ovr_clr     (ovr_clr),
        .divisor     (divisor),
        .brk_force   (brk_force),
        .txd         (txd),
        .hold_ready  (hold_ready),
        .shift_empty (shift_empty),
        .overrun     (overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic raw_write(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        while (!hold_ready) @(negedge clk);
        exp_q.push_back(d);
        raw_write(d);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || !shift_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: decodes frames from txd and compares against the scoreboard queue
    initial begin : monitor
        logic prev;
        logic [7:0] got;
        logic par, stp, st;
        logic [7:0] exp;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on && prev && !txd) begin
                repeat (period / 2) @(negedge clk);
                st = txd;
                for (int k = 0; k < 8; k++) begin
                    repeat (period) @(negedge clk);
                    got[k] = txd;
                end
                repeat (period) @(negedge clk);
                par = txd;
                repeat (period) @(negedge clk);
                stp = txd;
                if (exp_q.size() == 0) begin
                    check("R2 unexpected frame", 32'(got), 32'hDEAD);
                end else begin
                    exp = exp_q.pop_front();
                    check("R1 data LSB first", 32'(got), 32'(exp));
                    check("R8 start/parity/stop", {29'd0, st, par, stp}, {29'd0, 1'b0, ^exp, 1'b1});
                end
            end
            prev = txd;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        int ones;
        int run;
        repeat (3) @(negedge clk);
        check("R10 txd", 32'(txd), 32'd1);
        check("R10 hold_ready", 32'(hold_ready), 32'd1);
        check("R10 shift_empty", 32'(shift_empty), 32'd1);
        check("R10 overrun", 32'(overrun), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        mon_on = 1'b1;

        // R3: single write on idle line
        exp_q.push_back(8'h55);
        wr_data = 8'h55;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 hold_ready low after write", 32'(hold_ready), 32'd0);
        @(negedge clk);
        check("R3 hold_ready back", 32'(hold_ready), 32'd1);
        check("R5 shift_empty low", 32'(shift_empty), 32'd0);
        check("R3 start bit", 32'(txd), 32'd0);
        wait_idle();
        check("R5 shift_empty after frame", 32'(shift_empty), 32'd1);

        send(8'hA3);
        wait_idle();
        send(8'h00);
        wait_idle();
        send(8'hFF);
        wait_idle();

        // R2: back-to-back frames without gap
        send(8'h3C);
        send(8'hC1);
        repeat (5) @(negedge clk);
        check("R2 pending keeps hold_ready low", 32'(hold_ready), 32'd0);
        ones = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (shift_empty) ones++;
        end
        check("R2 no idle gap between frames", 32'(ones), 32'd0);
        wait_idle();

        // R4: overrun replaces pending character
        exp_q.push_back(8'h11);
        raw_write(8'h11);
        repeat (2) @(negedge clk);
        exp_q.push_back(8'h99);
        raw_write(8'h22);
        raw_write(8'h99);
        check("R4 overrun set", 32'(overrun), 32'd1);
        repeat (3) @(negedge clk);
        check("R4 overrun held", 32'(overrun), 32'd1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R4 overrun cleared", 32'(overrun), 32'd0);
        wait_idle();

        // R6: break forces low mid-frame
        mon_on = 1'b0;
        raw_write(8'hFF);
        repeat (10) @(negedge clk);
        brk_force = 1'b1;
        ones = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (txd) ones++;
        end
        check("R6 txd low during break", 32'(ones), 32'd0);
        brk_force = 1'b0;
        @(negedge clk);
        check("R6 frame continues", 32'(shift_empty), 32'd0);
        wait_idle();
        check("R6 line idle high after break", 32'(txd), 32'd1);

        // R7: bit time with divisor 0
        divisor = 16'd0;
        raw_write(8'h02);
        while (txd) @(negedge clk);
        run = 0;
        while (!txd) begin
            run++;
            @(negedge clk);
        end
        check("R7 bit time divisor 0", 32'(run), 32'd2);
        wait_idle();

        // R9: divisor change inside the start bit
        divisor = 16'd3;
        raw_write(8'h02);
        while (txd) @(negedge clk);
        divisor = 16'd9;
        run = 0;
        while (!txd) begin
            run++;
            @(negedge clk);
        end
        check("R9 change at bit boundary", 32'(run), 32'd14);
        wait_idle();
        divisor = 16'd3;
        repeat (4) @(negedge clk);

        // R8: frame after divisor restore
        mon_on = 1'b1;
        send(8'h5A);
        wait_idle();
        check("R8 idle high", 32'(txd), 32'd1);

        finish_run();
    end

endmodule